// File: doc/BRIEF.md
# Bus Clock-Enable Prescaler

This block runs entirely in the system clock domain. It turns two encoded divider settings into single-cycle enable strobes. One strobe paces a high-speed bus. The other paces a slower peripheral bus, and the peripheral bus divides the already-divided high-speed rate, not the system clock. Downstream logic uses the strobes as clock enables; no divided clock is ever generated. Both divider settings are plain inputs and may change at any time. A change is adopted only at the next period boundary of the strobe it affects, so the period in progress always runs to its full length.

For every peripheral on either bus, the block also produces an access-ready flag. Once a peripheral's clock-enable input is high, the flag rises after two ticks of that peripheral's own bus strobe. The flag falls in the same cycle the enable is withdrawn. Peripherals flagged as on-chip memory by a parameter mask are always clocked, so their flags stay high from reset onward.

Top module: `bus_clk_prescaler`

## Requirements
- R1: After reset, with both divider fields at 0, `hclk_en_o` and `pclk_en_o` are high in every cycle, and every non-memory ready flag is low.
- R2: The 4-bit `hdiv_cfg_i` sets the high-speed period in system cycles. Codes 0 to 7 give 1. Codes 8, 9, 10 and 11 give 2, 4, 8 and 16. Codes 12, 13, 14 and 15 give 64, 128, 256 and 512. No code gives 32. `hclk_en_o` is high for exactly one cycle per period.
- R3: The 3-bit `pdiv_cfg_i` sets how many high-speed strobes make one peripheral strobe. Codes 0 to 3 give 1. Codes 4, 5, 6 and 7 give 2, 4, 8 and 16. The peripheral period in system cycles is therefore the product of the two divisors.
- R4: `pclk_en_o` is high only in cycles where `hclk_en_o` is also high.
- R5: A new divider code is adopted at the first strobe of the affected bus after the change. The period in progress keeps its old length, and the first full period after that strobe has the new length.
- R6: A high-speed peripheral's ready flag rises one cycle after the second cycle in which both its enable and `hclk_en_o` are high. A peripheral-bus flag behaves the same way, counting `pclk_en_o` instead.
- R7: Ready is low in any cycle whose enable input is low. After the enable is withdrawn, the count starts again from zero.
- R8: A peripheral whose bit is set in its bus's memory mask reports ready in every cycle after reset, whatever its enable input.
- R9: With both divisors at 1, a peripheral becomes ready two cycles after its enable is first high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hdiv_cfg_i | input | 4 | High-speed bus divider code |
| pdiv_cfg_i | input | 3 | Peripheral bus divider code |
| hp_en_i | input | NUM_HP | Clock enables of high-speed bus peripherals |
| lp_en_i | input | NUM_LP | Clock enables of peripheral bus peripherals |
| hclk_en_o | output | 1 | High-speed bus clock-enable strobe |
| pclk_en_o | output | 1 | Peripheral bus clock-enable strobe |
| hp_ready_o | output | NUM_HP | Access-ready flags, high-speed bus peripherals |
| lp_ready_o | output | NUM_LP | Access-ready flags, peripheral bus peripherals |

## Verification
The bench builds the block with three high-speed peripherals and two peripheral-bus peripherals. The first high-speed peripheral is marked as memory and the peripheral-bus memory mask is empty. This exercises the always-on path and both counted-ready paths side by side, on strobes of different rates. The default divider width of nine shifts is kept, so the largest codes are reachable. A peripheral period of 512 × 16 cycles fits in the run, and so do divider changes made in the middle of a period on both buses.

// File: rtl/bcp_pkg.sv
package bcp_pkg;

    localparam int HDIV_W    = 4;
    localparam int PDIV_W    = 3;
    localparam int SHIFT_W   = 4;
    localparam int H_MAX_SH  = 9;
    localparam int P_MAX_SH  = 4;

    typedef logic [SHIFT_W-1:0] shift_t;

    typedef struct packed {
        logic hclk;
        logic pclk;
    } bus_strobe_t;

    // High-speed code: top bit clear means divide by 1; otherwise the
    // low three bits index a log2 table that skips divide by 32.
    function automatic shift_t hdiv_to_shift(input logic [HDIV_W-1:0] code);
        shift_t sh;
        if (!code[3]) begin
            sh = '0;
        end else begin
            case (code[2:0])
                3'd0:    sh = shift_t'(1);
                3'd1:    sh = shift_t'(2);
                3'd2:    sh = shift_t'(3);
                3'd3:    sh = shift_t'(4);
                3'd4:    sh = shift_t'(6);
                3'd5:    sh = shift_t'(7);
                3'd6:    sh = shift_t'(8);
                default: sh = shift_t'(9);
            endcase
        end
        return sh;
    endfunction

    // Peripheral code: top bit clear means divide by 1, else 2^(low+1).
    function automatic shift_t pdiv_to_shift(input logic [PDIV_W-1:0] code);
        shift_t sh;
        if (!code[2]) sh = '0;
        else          sh = shift_t'({1'b0, code[1:0]}) + shift_t'(1);
        return sh;
    endfunction

endpackage

// File: rtl/bcp_tick_gen.sv
module bcp_tick_gen
    import bcp_pkg::*;
#(
    parameter int MAX_SHIFT = 9
) (
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   adv_i,
    input  shift_t shift_i,
    output logic   tick_o
);
    localparam int CNT_W = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

    logic [CNT_W-1:0] cnt_q;
    shift_t           cur_sh_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] last;

    always_comb begin
        span = (CNT_W+1)'(1) << cur_sh_q;
        last = span[CNT_W-1:0] - CNT_W'(1);
    end

    assign tick_o = adv_i && (cnt_q == last);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q    <= '0;
            cur_sh_q <= '0;
        end else if (adv_i) begin
            if (tick_o) begin
                cnt_q    <= '0;
                cur_sh_q <= shift_i;
            end else begin
                cnt_q    <= cnt_q + CNT_W'(1);
            end
        end
    end

    always_comb begin
        AST_SHIFT_LEGAL: assert (rst_i || (int'(shift_i) <= MAX_SHIFT)); // R2
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= last); // R2

    AST_SHIFT_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_o |=> $stable(cur_sh_q)); // R5

endmodule

// File: rtl/bcp_ready_track.sv
module bcp_ready_track #(
    parameter int TICKS     = 2,
    parameter bit ALWAYS_ON = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic tick_i,
    output logic ready_o
);
    localparam int CW = $clog2(TICKS + 1);

    generate
        if (ALWAYS_ON) begin : g_mem
            assign ready_o = 1'b1;
        end else begin : g_cnt
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk_i) begin
                if (rst_i || !en_i) begin
                    cnt_q <= '0;
                end else if (tick_i && (cnt_q != CW'(TICKS))) begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end

            assign ready_o = en_i && (cnt_q == CW'(TICKS));

            AST_READY_RISES_ON_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
                $rose(ready_o) |-> ($past(tick_i) && $past(en_i))); // R6

            AST_READY_RESTARTS: assert property (@(posedge clk_i) disable iff (rst_i)
                !en_i |=> !ready_o); // R7
        end
    endgenerate

endmodule

// File: rtl/bus_clk_prescaler.sv
module bus_clk_prescaler
    import bcp_pkg::*;
#(
    parameter int             NUM_HP      = 4,
    parameter int             NUM_LP      = 4,
    parameter int             READY_TICKS = 2,
    parameter logic [NUM_HP-1:0] HP_MEM_MASK = NUM_HP'(1),
    parameter logic [NUM_LP-1:0] LP_MEM_MASK = '0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [3:0]        hdiv_cfg_i,
    input  logic [2:0]        pdiv_cfg_i,
    input  logic [NUM_HP-1:0] hp_en_i,
    input  logic [NUM_LP-1:0] lp_en_i,
    output logic              hclk_en_o,
    output logic              pclk_en_o,
    output logic [NUM_HP-1:0] hp_ready_o,
    output logic [NUM_LP-1:0] lp_ready_o
);
    bus_strobe_t strobe;
    shift_t      h_shift;
    shift_t      p_shift;

    assign h_shift = hdiv_to_shift(hdiv_cfg_i);
    assign p_shift = pdiv_to_shift(pdiv_cfg_i);

    bcp_tick_gen #(.MAX_SHIFT(H_MAX_SH)) u_hgen (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .adv_i   (1'b1),
        .shift_i (h_shift),
        .tick_o  (strobe.hclk)
    );

    bcp_tick_gen #(.MAX_SHIFT(P_MAX_SH)) u_pgen (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .adv_i   (strobe.hclk),
        .shift_i (p_shift),
        .tick_o  (strobe.pclk)
    );

    assign hclk_en_o = strobe.hclk;
    assign pclk_en_o = strobe.pclk;

    for (genvar i = 0; i < NUM_HP; i++) begin : g_hp
        bcp_ready_track #(.TICKS(READY_TICKS), .ALWAYS_ON(HP_MEM_MASK[i])) u_trk (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .en_i    (hp_en_i[i]),
            .tick_i  (strobe.hclk),
            .ready_o (hp_ready_o[i])
        );
    end

    for (genvar j = 0; j < NUM_LP; j++) begin : g_lp
        bcp_ready_track #(.TICKS(READY_TICKS), .ALWAYS_ON(LP_MEM_MASK[j])) u_trk (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .en_i    (lp_en_i[j]),
            .tick_i  (strobe.pclk),
            .ready_o (lp_ready_o[j])
        );
    end

    AST_PCLK_WITHIN_HCLK: assert property (@(posedge clk_i) disable iff (rst_i)
        pclk_en_o |-> hclk_en_o); // R4

    AST_MEM_ALWAYS_READY: assert property (@(posedge clk_i) disable iff (rst_i)
        ((hp_ready_o & HP_MEM_MASK) == HP_MEM_MASK)); // R8

endmodule

// File: tb/tb_bus_clk_prescaler.sv
module tb_bus_clk_prescaler;

    localparam int NHP = 3;
    localparam int NLP = 2;
    localparam logic [NHP-1:0] HMASK = 3'b001;

    typedef struct {
        logic           h;
        logic           p;
        logic [NHP-1:0] hr;
        logic [NLP-1:0] lr;
        int             cyc;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [3:0]     hcfg = '0;
    logic [2:0]     pcfg = '0;
    logic [NHP-1:0] hen = '0;
    logic [NLP-1:0] len = '0;
    logic           hclk_en, pclk_en;
    logic [NHP-1:0] hrdy;
    logic [NLP-1:0] lrdy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    exp_t q[$];

    // reference model state
    int m_hcnt = 0, m_hper = 1, m_pcnt = 0, m_pper = 1;
    int m_hc[NHP];
    int m_lc[NLP];
    int last_h = -1, gap_h = 0;

    always #10 clk = ~clk;

    bus_clk_prescaler #(
        .NUM_HP(NHP), .NUM_LP(NLP), .READY_TICKS(2),
        .HP_MEM_MASK(HMASK), .LP_MEM_MASK('0)
    ) dut (
        .clk_i(clk), .rst_i(rst), .hdiv_cfg_i(hcfg), .pdiv_cfg_i(pcfg),
        .hp_en_i(hen), .lp_en_i(len), .hclk_en_o(hclk_en), .pclk_en_o(pclk_en),
        .hp_ready_o(hrdy), .lp_ready_o(lrdy)
    );

    function automatic int hdecode(input logic [3:0] c);
        case (c)
            4'd8:  return 2;    4'd9:  return 4;
            4'd10: return 8;    4'd11: return 16;
            4'd12: return 64;   4'd13: return 128;
            4'd14: return 256;  4'd15: return 512;
            default: return 1;
        endcase
    endfunction

    function automatic int pdecode(input logic [2:0] c);
        case (c)
            3'd4: return 2;  3'd5: return 4;
            3'd6: return 8;  3'd7: return 16;
            default: return 1;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    // driver side: compute and push the expected item of this cycle
    task automatic push_expected();
        exp_t e;
        e.h = (m_hcnt == m_hper - 1);
        e.p = e.h && (m_pcnt == m_pper - 1);
        for (int i = 0; i < NHP; i++)
            e.hr[i] = HMASK[i] ? 1'b1 : (hen[i] && m_hc[i] >= 2);
        for (int i = 0; i < NLP; i++)
            e.lr[i] = len[i] && m_lc[i] >= 2;
        e.cyc = cyc;
        q.push_back(e);
    endtask

    task automatic model_step(input exp_t e);
        for (int i = 0; i < NHP; i++)
            if (!hen[i]) m_hc[i] = 0;
            else if (e.h && m_hc[i] < 2) m_hc[i]++;
        for (int i = 0; i < NLP; i++)
            if (!len[i]) m_lc[i] = 0;
            else if (e.p && m_lc[i] < 2) m_lc[i]++;
        if (e.h) begin
            if (e.p) begin m_pcnt = 0; m_pper = pdecode(pcfg); end
            else m_pcnt++;
            m_hcnt = 0; m_hper = hdecode(hcfg);
        end else begin
            m_hcnt++;
        end
    endtask

    // monitor: sample away from the active edge, pop and compare
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            m_hcnt = 0; m_hper = 1; m_pcnt = 0; m_pper = 1;
            for (int i = 0; i < NHP; i++) m_hc[i] = 0;
            for (int i = 0; i < NLP; i++) m_lc[i] = 0;
            last_h = -1;
        end else begin
            exp_t e;
            push_expected();
            e = q.pop_front();
            check("R2 R5 hclk_en", 32'(hclk_en), 32'(e.h));
            check("R3 R5 pclk_en", 32'(pclk_en), 32'(e.p));
            check("R6 R7 R9 hp_ready", 32'(hrdy), 32'(e.hr));
            check("R6 R7 lp_ready", 32'(lrdy), 32'(e.lr));
            if (pclk_en) check("R4 pclk inside hclk", 32'(hclk_en), 32'd1);
            if (hclk_en) begin
                if (last_h >= 0) gap_h = e.cyc - last_h;
                last_h = e.cyc;
            end
            model_step(e);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        @(negedge clk); #1;
        check("R1 hclk at reset", 32'(hclk_en), 32'd1);
        check("R1 pclk at reset", 32'(pclk_en), 32'd1);
        check("R1 ready low at reset", 32'(hrdy[2:1]), 32'd0);
        check("R8 memory ready without enable", 32'(hrdy[0]), 32'd1);
        wait_cyc(1);

        // R9: both divisors 1, enable becomes ready after two cycles
        hen[1] = 1'b1; len[0] = 1'b1;
        wait_cyc(1); @(negedge clk); #1;
        check("R9 not yet ready", 32'(hrdy[1]), 32'd0);
        wait_cyc(1); @(negedge clk); #1;
        check("R9 ready after two", 32'(hrdy[1]), 32'd1);
        wait_cyc(4);

        // R7: withdraw and re-enable
        hen[1] = 1'b0; #1;
        check("R7 drop same cycle", 32'(hrdy[1]), 32'd0);
        wait_cyc(1);
        hen[1] = 1'b1;
        wait_cyc(1); @(negedge clk); #1;
        check("R7 restart count", 32'(hrdy[1]), 32'd0);
        wait_cyc(3);

        // codes 0-7 and 0-3 still divide by 1
        hcfg = 4'd5; pcfg = 3'd2;
        wait_cyc(10);

        // divide by 4 / 4, change mid-period
        hcfg = 4'd9; pcfg = 3'd5; hen[2] = 1'b1; len[1] = 1'b1;
        wait_cyc(101);
        hcfg = 4'd8; pcfg = 3'd4;
        wait_cyc(47);
        hcfg = 4'd11; pcfg = 3'd6;
        wait_cyc(300);
        check("R2 divide-by-16 spacing", 32'(gap_h), 32'd16);

        // every high-speed code
        for (int c = 8; c < 16; c++) begin
            hcfg = 4'(c); pcfg = 3'd7;
            wait_cyc(3 * hdecode(4'(c)) + 5);
        end
        check("R2 divide-by-512 spacing", 32'(gap_h), 32'd512);
        len[0] = 1'b0;
        wait_cyc(3);
        len[0] = 1'b1;
        wait_cyc(2 * 512 * 16 + 600);
        check("R6 lp ready after two slow ticks", 32'(lrdy[0]), 32'd1);

        hcfg = 4'd12; pcfg = 3'd7;
        wait_cyc(9000);
        check("R2 divide-by-64 spacing", 32'(gap_h), 32'd64);
        hcfg = 4'd0; pcfg = 3'd0;
        wait_cyc(2000);
        check("R5 back to divide-by-1", 32'(gap_h), 32'd1);
        summary();
    end

endmodule